// File: doc/BRIEF.md
# Debounced 4x4 Keypad Scanner

This block scans a sixteen-key matrix of four row drive lines (active low) and four column sense lines (pulled high, so an open column reads 1). While idle it pulls every row low at once, so any closed key shows up as a low column. Before it will accept a key it must see the whole pad open, both at first sight and again after a debounce interval. Only then does it arm and wait for a closure, which is accepted if it is still present after a second debounce interval.

Once a closure has been accepted, the scanner pulls one row low at a time, starting at row 0 and moving up one row per clock, until a column reads low. The row and column numbers then form a key index equal to row times four plus column. The index is turned into its ASCII hexadecimal character and presented with a one-cycle valid strobe. After each code the scanner goes back to waiting for a full release, so a key held down yields one code only. If the key is let go during the row search and no row produces a hit, the search is dropped and no code is produced.

Top module: `kpd_scanner`

## Requirements
- R1: While reset is high and in the first cycle after it, `row_drv` is 4'b0000, `key_valid` is 0 and `key_char` is 8'h00.
- R2: At any time `row_drv` is either 4'b0000 (all rows pulled for detection) or has exactly one bit low (row search).
- R3: A code is produced only after the pad has read fully open (`col_in` = 4'hF) at the start and again at the end of a debounce interval of `DB_CYCLES` clocks; a key held across reset yields no code until it is released and pressed again.
- R4: A closure that is gone by the end of its `DB_CYCLES` debounce interval yields no code.
- R5: The row search drives 4'b1110 first (row 0 low) and, while all columns read high, moves the low bit one position up each clock (1110, 1101, 1011, 0111).
- R6: The key index is row number times 4 plus column number, where the row number is the bit position of the low `row_drv` bit and the column number is the bit position of the low `col_in` bit, counted from bit 0 (the lowest low bit wins).
- R7: Index values 0 to 9 give `key_char` 8'h30 to 8'h39 and values 10 to 15 give 8'h41 to 8'h46.
- R8: `key_valid` is high for exactly one clock per accepted key, in the clock after the hit, and `key_char` holds the code during that clock.
- R9: A key held closed after its code gives no further code until it has been released.
- R10: If all four rows are tried with no column low, the search ends: `row_drv` returns to 4'b0000 in the next clock, no code is produced, and the scanner goes back to waiting for a release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_in | input | 4 | Column sense lines, low means a closed key in a driven row |
| row_drv | output | 4 | Row drive lines, low means the row is driven |
| key_valid | output | 1 | One-clock strobe for a new key code |
| key_char | output | 8 | ASCII hexadecimal character of the key |

## Verification
A scanner stuck in a wrong state shows up almost at once on `row_drv`: a search that does not start at row 0, skips a row or fails to return to all-low after the fourth row is seen within one to four clocks of the accepted closure. A wrong row or column count appears as a wrong character on the single strobe clock. A debounce or release-arming fault is slower to show, since it only becomes visible as an extra or missing strobe one debounce interval after a bounce, a held key, or a release that happens during the search.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    localparam int KP_ROWS = 4;
    localparam int KP_COLS = 4;

    typedef enum logic [2:0] {
        ST_REL_WAIT,
        ST_REL_DB,
        ST_PRS_WAIT,
        ST_PRS_DB,
        ST_SCAN
    } scan_state_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] pos;
    } col_hit_t;

    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
    } key_pos_t;

    function automatic col_hit_t find_low_col(input logic [KP_COLS-1:0] c);
        col_hit_t r;
        r.hit = 1'b0;
        r.pos = 2'd0;
        for (int i = KP_COLS - 1; i >= 0; i--) begin
            if (!c[i]) begin
                r.hit = 1'b1;
                r.pos = 2'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] hex_ascii(input logic [3:0] idx);
        if (idx < 4'd10)
            return 8'h30 + {4'h0, idx};
        else
            return 8'h37 + {4'h0, idx};
    endfunction

endpackage

// File: rtl/kpd_db_timer.sv
module kpd_db_timer #(
    parameter int CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/kpd_col_find.sv
module kpd_col_find
    import kpd_pkg::*;
(
    input  logic [KP_COLS-1:0] cols,
    output col_hit_t           found
);
    always_comb found = find_low_col(cols);
endmodule

// File: rtl/kpd_encoder.sv
module kpd_encoder
    import kpd_pkg::*;
(
    input  key_pos_t   pos,
    output logic [7:0] ascii
);
    always_comb ascii = hex_ascii({pos.row, pos.col});
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner
    import kpd_pkg::*;
#(
    parameter int DB_CYCLES = 1_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] col_in,
    output logic [3:0] row_drv,
    output logic       key_valid,
    output logic [7:0] key_char
);
    scan_state_t state;
    logic [KP_ROWS-1:0] row_pat;
    logic [1:0]         row_num;
    logic               tmr_run;
    logic               tmr_done;
    col_hit_t           col_hit;
    key_pos_t           hit_pos;
    logic [7:0]         hit_char;

    assign tmr_run = (state == ST_REL_DB) || (state == ST_PRS_DB);

    kpd_db_timer #(.CYCLES(DB_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (tmr_run),
        .done (tmr_done)
    );

    kpd_col_find u_colf (
        .cols  (col_in),
        .found (col_hit)
    );

    assign hit_pos.row = row_num;
    assign hit_pos.col = col_hit.pos;

    kpd_encoder u_enc (
        .pos   (hit_pos),
        .ascii (hit_char)
    );

    assign row_drv = (state == ST_SCAN) ? row_pat : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_REL_WAIT;
            row_pat   <= 4'b1110;
            row_num   <= 2'd0;
            key_valid <= 1'b0;
            key_char  <= 8'h00;
        end else begin
            key_valid <= 1'b0;
            case (state)
                ST_REL_WAIT: begin
                    if (!col_hit.hit)
                        state <= ST_REL_DB;
                end
                ST_REL_DB: begin
                    if (tmr_done)
                        state <= col_hit.hit ? ST_REL_WAIT : ST_PRS_WAIT;
                end
                ST_PRS_WAIT: begin
                    if (col_hit.hit)
                        state <= ST_PRS_DB;
                end
                ST_PRS_DB: begin
                    if (tmr_done) begin
                        if (col_hit.hit) begin
                            state   <= ST_SCAN;
                            row_pat <= 4'b1110;
                            row_num <= 2'd0;
                        end else begin
                            state <= ST_PRS_WAIT;
                        end
                    end
                end
                ST_SCAN: begin
                    if (col_hit.hit) begin
                        key_char  <= hit_char;
                        key_valid <= 1'b1;
                        state     <= ST_REL_WAIT;
                    end else if (row_num == 2'd3) begin
                        state <= ST_REL_WAIT;
                    end else begin
                        row_pat <= {row_pat[2:0], row_pat[3]};
                        row_num <= row_num + 2'd1;
                    end
                end
                default: state <= ST_REL_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/kpd_scanner_chk.sv
module kpd_scanner_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] col_in,
    input logic [3:0] row_drv,
    input logic       key_valid,
    input logic [7:0] key_char
);
    logic [3:0] prev_rows;

    always_ff @(posedge clk) prev_rows <= row_drv;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (row_drv == 4'b0000 && !key_valid && key_char == 8'h00));

    p_row_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (row_drv == 4'b0000) || ($countones(row_drv) == 3));

    p_row_step_r5: assert property (@(posedge clk) disable iff (rst)
        (row_drv != 4'b0000 && row_drv != 4'b0111 && col_in == 4'hF)
        |=> row_drv == {prev_rows[2:0], prev_rows[3]});

    p_hit_emits_r6: assert property (@(posedge clk) disable iff (rst)
        (row_drv != 4'b0000 && col_in != 4'hF) |=> (key_valid && row_drv == 4'b0000));

    p_char_range_r7: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> ((key_char >= 8'h30 && key_char <= 8'h39) ||
                       (key_char >= 8'h41 && key_char <= 8'h46)));

    p_one_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);

    p_no_code_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (row_drv == 4'b0000) |=> !key_valid);

    p_give_up_r10: assert property (@(posedge clk) disable iff (rst)
        (row_drv == 4'b0111 && col_in == 4'hF) |=> (row_drv == 4'b0000 && !key_valid));
endmodule

bind kpd_scanner kpd_scanner_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .col_in    (col_in),
    .row_drv   (row_drv),
    .key_valid (key_valid),
    .key_char  (key_char)
);

// File: tb/kpd_scanner_bench.sv
module kpd_scanner_bench;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] col_in;
    logic [3:0] row_drv;
    logic       key_valid;
    logic [7:0] key_char;

    logic pressed = 1'b0;
    int   prow = 0;
    int   pcol = 0;

    int checks = 0;
    int bad    = 0;

    always #10 clk = ~clk;

    kpd_scanner #(.DB_CYCLES(N)) u_kpd_scanner (
        .clk       (clk),
        .rst       (rst),
        .col_in    (col_in),
        .row_drv   (row_drv),
        .key_valid (key_valid),
        .key_char  (key_char)
    );

    // matrix model: a closed key pulls its column low when its row is driven
    always_comb begin
        col_in = 4'hF;
        if (pressed && row_drv[prow] == 1'b0)
            col_in[pcol] = 1'b0;
    end

    // {row, col, expected ASCII}
    localparam logic [11:0] VEC [16] = '{
        {2'd0, 2'd0, 8'h30}, {2'd2, 2'd3, 8'h42}, {2'd1, 2'd1, 8'h35},
        {2'd3, 2'd3, 8'h46}, {2'd0, 2'd2, 8'h32}, {2'd2, 2'd1, 8'h39},
        {2'd3, 2'd0, 8'h43}, {2'd1, 2'd3, 8'h37}, {2'd0, 2'd1, 8'h31},
        {2'd2, 2'd2, 8'h41}, {2'd1, 2'd0, 8'h34}, {2'd3, 2'd2, 8'h45},
        {2'd0, 2'd3, 8'h33}, {2'd2, 2'd0, 8'h38}, {2'd1, 2'd2, 8'h36},
        {2'd3, 2'd1, 8'h44}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count strobe cycles over a window, keep the last character seen
    task automatic watch(input int n, output int pulses, output logic [7:0] ch);
        pulses = 0;
        ch = 8'h00;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (key_valid) begin
                pulses++;
                ch = key_char;
            end
        end
    endtask

    task automatic press(input int r, input int c);
        prow = r;
        pcol = c;
        pressed = 1'b1;
    endtask

    task automatic release_and_arm();
        pressed = 1'b0;
        cyc(N + 5);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", checks + 1, bad);
        $finish;
    end

    initial begin : main
        int p;
        logic [7:0] ch;
        int ok_seq;

        // R1: reset state
        cyc(3);
        check(row_drv == 4'b0000 && !key_valid && key_char == 8'h00, "R1",
              "outputs in reset", {row_drv, key_valid, key_char}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(row_drv == 4'b0000 && !key_valid && key_char == 8'h00, "R1",
              "outputs after reset", {row_drv, key_valid, key_char}, 0);
        cyc(N + 5);

        // R6 R7 R8 R9: every key from the table
        for (int v = 0; v < 16; v++) begin
            press(int'(VEC[v][11:10]), int'(VEC[v][9:8]));
            watch(N + 10, p, ch);
            check(p == 1, "R8", "strobe count per press", p, 1);
            check(ch == VEC[v][7:0], "R7", "key character", ch, VEC[v][7:0]);
            watch(3 * N, p, ch);
            check(p == 0, "R9", "strobes while held", p, 0);
            release_and_arm();
        end

        // R5: row walk order for a key in row 3, column 1
        press(3, 1);
        p = 0;
        while (row_drv == 4'b0000 && p < 4 * N) begin
            @(negedge clk);
            p++;
        end
        ok_seq = (row_drv == 4'b1110) ? 1 : 0;
        check(ok_seq == 1, "R5", "first search row", row_drv, 4'b1110);
        @(negedge clk);
        check(row_drv == 4'b1101, "R5", "second search row", row_drv, 4'b1101);
        @(negedge clk);
        check(row_drv == 4'b1011, "R5", "third search row", row_drv, 4'b1011);
        @(negedge clk);
        check(row_drv == 4'b0111, "R5", "fourth search row", row_drv, 4'b0111);
        @(negedge clk);
        check(key_valid && key_char == 8'h44, "R6", "strobe after row 3 hit",
              {key_valid, key_char}, {1'b1, 8'h44});
        check(row_drv == 4'b0000, "R2", "rows back to all low", row_drv, 0);
        release_and_arm();

        // R4: bounce shorter than debounce
        press(1, 2);
        cyc(N / 2);
        pressed = 1'b0;
        watch(3 * N, p, ch);
        check(p == 0, "R4", "strobes after short bounce", p, 0);

        // R10: key released as the search starts
        press(3, 2);
        p = 0;
        while (row_drv != 4'b1110 && p < 4 * N) begin
            @(negedge clk);
            p++;
        end
        pressed = 1'b0;
        cyc(4);
        check(row_drv == 4'b0000, "R10", "rows after empty search", row_drv, 0);
        watch(3 * N, p, ch);
        check(p == 0, "R10", "strobes after empty search", p, 0);
        press(2, 3);
        watch(N + 10, p, ch);
        check(p == 1 && ch == 8'h42, "R10", "code after recovery", ch, 8'h42);
        release_and_arm();

        // R3: key held across reset gives nothing until released
        press(0, 1);
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        watch(4 * N, p, ch);
        check(p == 0, "R3", "strobes with key held since reset", p, 0);
        check(row_drv == 4'b0000, "R2", "rows all low while waiting", row_drv, 0);
        release_and_arm();
        press(0, 1);
        watch(N + 10, p, ch);
        check(p == 1 && ch == 8'h31, "R3", "code after release and press", ch, 8'h31);
        release_and_arm();

        // R3: release that reverts before the release debounce ends
        press(1, 1);
        watch(N + 10, p, ch);
        pressed = 1'b0;
        cyc(N / 2);
        press(1, 1);
        watch(4 * N, p, ch);
        check(p == 0, "R3", "strobes after unconfirmed release", p, 0);
        release_and_arm();

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule